// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency synthesizer, modelled as synchronous logic that runs on the oscillator-rate clock. It divides the clock by M×N+A. M is the prescaler modulus, chosen as 64 or 128 by a select bit. N is an 11-bit program value and A is a 7-bit swallow value. Once per completed division it emits a comparison pulse that lasts one clock. A phase comparator downstream sets this pulse against the reference.

Inside, a digital prescaler divides by M+1 for the first A prescaler cycles of each period and by M for the remaining N−A cycles. A swallow counter and a program counter keep track of these cycles. The programmed values are sampled only at a period boundary, so every period runs entirely on one setting. If the inputs break the rules (N below 3, or A not smaller than N), an error output is raised and the last valid setting stays in force.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While reset is low, `fp_pulse` is 0. At the first clock after reset the divider loads its setting without pulsing. The first pulse follows one full period later. The setting in force after reset is M=64, N=3, A=0.
- R2: `fp_pulse` is high for one clock per period. The distance between two consecutive pulses is M×N+A clocks.
- R3: `mod_sel`=1 selects M=64 and `mod_sel`=0 selects M=128.
- R4: With A=0 the period is exactly M×N clocks.
- R5: Swallow values at the edge of the legal range behave exactly like other values: A=N−1, and A=127 with N=128.
- R6: A change of `mod_sel`, `swallow_a` or `prog_n` in the middle of a period does not alter that period. The new setting takes effect from the next period boundary.
- R7: `cfg_err` is 1 in the same cycle whenever `prog_n` < 3 or `swallow_a` ≥ `prog_n`, and 0 otherwise.
- R8: A setting that raises `cfg_err` at a period boundary is not taken. The previous valid setting stays in force for the next period.
- R9: `fp_pulse` is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_sel | input | 1 | Prescaler modulus select: 1 gives 64/65, 0 gives 128/129 |
| swallow_a | input | 7 | Swallow value A |
| prog_n | input | 11 | Program value N |
| fp_pulse | output | 1 | One-clock comparison pulse at the end of each period |
| cfg_err | output | 1 | Current inputs form an illegal setting |

## Verification
The divider is driven with several settings. A=0 under both moduli separates the M×N term from the swallow term. Small nonzero A values under each modulus show that exactly A prescaler cycles are stretched and that M is 64 or 128, not some other value. The cases A=N−1 and A=127 with N=128 exercise the swallow counter running until the last prescaler cycle. A setting changed mid-period, and illegal settings applied across a boundary, show whether a period ever mixes two settings and whether a rejected setting leaks into the divider.

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int AW      = 7,
  parameter int NW      = 11,
  parameter int M_SMALL = 64,
  parameter int M_LARGE = 128,
  parameter int N_MIN   = 3,
  parameter int RST_N   = 3,
  parameter int RST_A   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_sel,
  input  logic [AW-1:0] swallow_a,
  input  logic [NW-1:0] prog_n,
  output logic          fp_pulse,
  output logic          cfg_err
);
  localparam int PW = $clog2(M_LARGE + 1);

  logic [AW-1:0] act_a, sw_cnt, sw_next, nxt_a;
  logic [NW-1:0] act_n, n_cnt, nxt_n;
  logic          act_sel, nxt_sel, load, pre_wrap;
  logic [PW-1:0] pre_cnt, pre_base, nxt_base;

  assign cfg_err  = (prog_n < NW'(N_MIN)) || (NW'(swallow_a) >= prog_n);
  assign nxt_a    = cfg_err ? act_a   : swallow_a;
  assign nxt_n    = cfg_err ? act_n   : prog_n;
  assign nxt_sel  = cfg_err ? act_sel : mod_sel;

  assign pre_wrap = (pre_cnt == '0);
  assign load     = (n_cnt == '0) || (pre_wrap && (n_cnt == NW'(1)));
  assign pre_base = act_sel ? PW'(M_SMALL - 1) : PW'(M_LARGE - 1);
  assign nxt_base = nxt_sel ? PW'(M_SMALL - 1) : PW'(M_LARGE - 1);
  assign sw_next  = (sw_cnt != '0) ? sw_cnt - AW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a    <= AW'(RST_A);
      act_n    <= NW'(RST_N);
      act_sel  <= 1'b1;
      n_cnt    <= '0;
      sw_cnt   <= '0;
      pre_cnt  <= '0;
      fp_pulse <= 1'b0;
    end else begin
      fp_pulse <= load && (n_cnt != '0);
      if (load) begin
        act_a   <= nxt_a;
        act_n   <= nxt_n;
        act_sel <= nxt_sel;
        n_cnt   <= nxt_n;
        sw_cnt  <= nxt_a;
        pre_cnt <= nxt_base + PW'(nxt_a != '0);
      end else if (pre_wrap) begin
        n_cnt   <= n_cnt - NW'(1);
        sw_cnt  <= sw_next;
        pre_cnt <= pre_base + PW'(sw_next != '0);
      end else begin
        pre_cnt <= pre_cnt - PW'(1);
      end
    end
  end
endmodule

module psd_checker #(
  parameter int AW      = 7,
  parameter int NW      = 11,
  parameter int M_SMALL = 64,
  parameter int N_MIN   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp_pulse,
  input logic          load,
  input logic [NW-1:0] n_cnt,
  input logic [AW-1:0] sw_cnt,
  input logic [AW-1:0] act_a,
  input logic [NW-1:0] act_n,
  input logic          act_sel
);
  logic [19:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (fp_pulse) begin
      gap  <= 20'd1;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 20'd1;
    end
  end

  AST_FP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fp_pulse |=> !fp_pulse); // R9
  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n) (fp_pulse && seen) |-> (gap >= 20'(M_SMALL * N_MIN))); // R2
  AST_FIRST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (n_cnt == '0) |=> !fp_pulse); // R1
  AST_SWALLOW_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n) (n_cnt != '0) |-> (NW'(sw_cnt) < n_cnt)); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> ($stable(act_a) && $stable(act_n) && $stable(act_sel))); // R6
endmodule

bind pulse_swallow_divider psd_checker #(.AW(AW), .NW(NW), .M_SMALL(M_SMALL), .N_MIN(N_MIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .fp_pulse(fp_pulse), .load(load), .n_cnt(n_cnt),
  .sw_cnt(sw_cnt), .act_a(act_a), .act_n(act_n), .act_sel(act_sel)
);

// File: tb/pulse_swallow_divider_tb.sv
module pulse_swallow_divider_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, mod_sel = 1'b1;
  logic [6:0]  swallow_a = 7'd0;
  logic [10:0] prog_n = 11'd3;
  logic fp_pulse, cfg_err;

  pulse_swallow_divider dut_i (.clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .swallow_a(swallow_a),
                               .prog_n(prog_n), .fp_pulse(fp_pulse), .cfg_err(cfg_err));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit timed_out = 0, done = 0;
  string cur_req = "R1";

  // behavioural model: remaining clocks in the current period
  int  m_a = 0, m_n = 3, rem = 0;
  bit  m_sel = 1, started = 0, exp_fp = 0, prev_fp = 0;

  function automatic int period_of(bit sel, int n, int a);
    return (sel ? 64 : 128) * n + a;
  endfunction

  function automatic bit illegal(int n, int a);
    return (n < 3) || (a >= n);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      started = 0; m_a = 0; m_n = 3; m_sel = 1; exp_fp = 0;
    end else begin
      if (!started || rem == 1) begin
        exp_fp = started;
        started = 1;
        if (!illegal(int'(prog_n), int'(swallow_a))) begin
          m_a = int'(swallow_a); m_n = int'(prog_n); m_sel = mod_sel;
        end
        rem = period_of(m_sel, m_n, m_a);
      end else begin
        exp_fp = 0;
        rem--;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) chk(fp_pulse == 1'b0, "R1", int'(fp_pulse), 0);
      else begin
        chk(fp_pulse == exp_fp, cur_req, int'(fp_pulse), int'(exp_fp));
        chk(cfg_err == illegal(int'(prog_n), int'(swallow_a)), "R7", int'(cfg_err),
            int'(illegal(int'(prog_n), int'(swallow_a))));
        if (prev_fp) chk(fp_pulse == 1'b0, "R9", int'(fp_pulse), 0);
      end
      prev_fp = fp_pulse;
    end
  end

  task automatic wait_fp();
    do begin
      @(negedge clk);
      if (cyc > 150000) timed_out = 1;
    end while (!fp_pulse && !timed_out);
  endtask

  task automatic measure(int exp, string req);
    int t0;
    wait_fp(); t0 = cyc;
    wait_fp();
    chk((cyc - t0) == exp, req, cyc - t0, exp);
  endtask

  task automatic set_cfg(bit s, int n, int a);
    mod_sel = s; prog_n = 11'(n); swallow_a = 7'(a);
  endtask

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    t0 = cyc;
    wait_fp();
    chk((cyc - t0) == 193, "R1", cyc - t0, 193);
    cur_req = "R4"; measure(192, "R4");
    cur_req = "R2"; set_cfg(1, 5, 2);  wait_fp(); measure(322, "R2");
    cur_req = "R3"; set_cfg(0, 4, 3);  wait_fp(); measure(515, "R3");
    cur_req = "R4"; set_cfg(0, 6, 0);  wait_fp(); measure(768, "R4");
    cur_req = "R5"; set_cfg(1, 10, 9); wait_fp(); measure(649, "R5");
    set_cfg(1, 128, 127); wait_fp(); measure(8319, "R5");
    cur_req = "R6";
    t0 = cyc;
    repeat (100) @(negedge clk);
    set_cfg(1, 3, 1);
    wait_fp();
    chk((cyc - t0) == 8319, "R6", cyc - t0, 8319);
    measure(193, "R6");
    cur_req = "R7";
    set_cfg(1, 2, 0); #1 chk(cfg_err == 1'b1, "R7", int'(cfg_err), 1);
    @(negedge clk); set_cfg(1, 5, 5); #1 chk(cfg_err == 1'b1, "R7", int'(cfg_err), 1);
    @(negedge clk); set_cfg(1, 5, 4); #1 chk(cfg_err == 1'b0, "R7", int'(cfg_err), 0);
    @(negedge clk);
    cur_req = "R8";
    set_cfg(0, 2, 1); wait_fp(); measure(193, "R8");
    set_cfg(0, 7, 7); wait_fp(); measure(193, "R8");
    if (timed_out) chk(1'b0, "watchdog", cyc, 150000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule